// File: doc/BRIEF.md
# Status LED Blink Pattern Generator

This block drives one status LED so that a person looking at a board can tell how far power-up has progressed and whether the FPGA has been configured. A two-bit power-sequencer state code and a configuration-done flag are turned into one of five display patterns. Three of them use a repeating frame of eight equal slots. The number of lit slots identifies the sequencer state, and the lit slots always come first in the frame. A fault while waiting for the first supply rails is shown as fast, continuous blinking. Once power is ready and the FPGA is configured, the LED is handed to a user-controlled input.

Timing comes from a prescaler parameterised on the clock frequency. The base tick rate `BASE_HZ` is about 12 Hz, which gives a half-period of about 83 ms. The fast blink toggles once per half-period. A slot lasts two half-periods, about 167 ms, so a frame of eight slots repeats at roughly 0.75 Hz. Below, H stands for `CLK_HZ / BASE_HZ` clock cycles.

The display logic is a five-state machine with the states DISP_FAST, DISP_FRAME5, DISP_FRAME4, DISP_FRAME3 and DISP_USER. Each cycle the decoder names the wanted state. When that differs from the current state, the machine takes the transition "switch" straight to the wanted state in one cycle. The same switch restarts the prescaler, the fast-blink phase and the slot counter. When the wanted state equals the current one, the machine takes "hold" and stays. The LED output is registered, so it reflects the state and counters of the previous cycle.

Top module: `led_status_blinker`

## Requirements
- R1: While `rst_n` is low, `led` is 0. The display starts in DISP_FAST with all counters at zero.
- R2: State code 0 (idle) selects DISP_FAST. The LED is lit for H cycles and then dark for H cycles, repeating. The first lit interval starts in the cycle after entry.
- R3: State code 1 selects DISP_FRAME5. The frame lasts 16·H cycles and is made of 8 slots of 2·H cycles each. Slots 0 to 4 are lit and slots 5 to 7 are dark.
- R4: State code 2 selects DISP_FRAME4. Slots 0 to 3 of the 8-slot frame are lit.
- R5: State code 3 with `cfg_done` low selects DISP_FRAME3. Slots 0 to 2 are lit.
- R6: State code 3 with `cfg_done` high selects DISP_USER. `led` then equals `user_led` as sampled one clock earlier.
- R7: A change of the selected display state restarts the slot count at slot 0 and the blink phase at its lit half. The new pattern appears on `led` one cycle after the state change. While the selection is unchanged, the frame repeats with no break.
- R8: `cfg_done` has no effect while the state code is 0, 1 or 2. Toggling it in those states neither changes the pattern nor restarts the frame. `user_led` has no effect outside DISP_USER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_state | input | 2 | Power-sequencer state code (0 idle, 1 first stage, 2 second stage, 3 ready) |
| cfg_done | input | 1 | FPGA configuration done |
| user_led | input | 1 | User-controlled LED value, used after configuration |
| led | output | 1 | LED drive, 1 = lit |

## Verification
The assertions check on every cycle that the registered LED value matches the pattern for the current display state. This covers the fast-blink phase, the slot-versus-lit-count comparison and the one-cycle user pass-through. They also check that a switch clears the slot and phase, that the slot holds between slot ticks, and that a steady non-ready code never causes a restart. The bench's scenarios show what needs whole stretches of time. These are the H-cycle half-periods, the 16·H-cycle frame repeating over several periods, the exact cycle at which a new pattern starts after an abrupt change between every pair of inputs, and the absence of any disturbance while `cfg_done` toggles in the non-ready states.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    // Power-sequencer state codes seen at the input.
    typedef enum logic [1:0] {
        PWR_IDLE  = 2'd0,
        PWR_STG1  = 2'd1,
        PWR_STG2  = 2'd2,
        PWR_READY = 2'd3
    } pwr_code_e;

    // Display states of the pattern machine.
    typedef enum logic [2:0] {
        DISP_FAST   = 3'd0,
        DISP_FRAME5 = 3'd1,
        DISP_FRAME4 = 3'd2,
        DISP_FRAME3 = 3'd3,
        DISP_USER   = 3'd4
    } disp_e;

    localparam int FRAME_SLOTS = 8;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS);

    // Number of lit slots at the head of the frame for each frame state.
    function automatic logic [SLOT_W:0] lit_slots(input disp_e d);
        logic [SLOT_W:0] n;
        unique case (d)
            DISP_FRAME5: n = (SLOT_W+1)'(5);
            DISP_FRAME4: n = (SLOT_W+1)'(4);
            DISP_FRAME3: n = (SLOT_W+1)'(3);
            default:     n = '0;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/led_mode_decode.sv
module led_mode_decode
    import led_blink_pkg::*;
(
    input  logic [1:0] pwr_state,
    input  logic       cfg_done,
    output disp_e      req
);

    always_comb begin
        unique case (pwr_code_e'(pwr_state))
            PWR_IDLE:  req = DISP_FAST;
            PWR_STG1:  req = DISP_FRAME5;
            PWR_STG2:  req = DISP_FRAME4;
            PWR_READY: req = cfg_done ? DISP_USER : DISP_FRAME3;
            default:   req = DISP_FAST;
        endcase
    end

endmodule

// File: rtl/led_prescaler.sv
module led_prescaler #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic phase,
    output logic slot_tick
);

    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;
    logic          half_tick;

    assign half_tick = !restart && (cnt == LAST);
    assign slot_tick = half_tick && phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= 1'b0;
        end else if (restart) begin
            phase <= 1'b0;
        end else if (half_tick) begin
            phase <= ~phase;
        end
    end

endmodule

// File: rtl/led_slot_counter.sv
module led_slot_counter
    import led_blink_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              slot_tick,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_SLOTS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (restart) begin
            slot <= '0;
        end else if (slot_tick) begin
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end
    end

endmodule

// File: rtl/led_status_blinker.sv
module led_status_blinker
    import led_blink_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int BASE_HZ = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_state,
    input  logic       cfg_done,
    input  logic       user_led,
    output logic       led
);

    localparam int HALF_CYC = (CLK_HZ / BASE_HZ < 2) ? 2 : CLK_HZ / BASE_HZ;

    disp_e             req;
    disp_e             state_q;
    logic              restart;
    logic              phase;
    logic              slot_tick;
    logic [SLOT_W-1:0] slot;
    logic              led_q;

    led_mode_decode u_decode (
        .pwr_state (pwr_state),
        .cfg_done  (cfg_done),
        .req       (req)
    );

    // Transition "switch" whenever the wanted state differs from the current one.
    assign restart = (req != state_q);

    led_prescaler #(.HALF_CYC(HALF_CYC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .phase     (phase),
        .slot_tick (slot_tick)
    );

    led_slot_counter u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .slot_tick (slot_tick),
        .slot      (slot)
    );

    // State register: "hold" keeps the state, "switch" jumps to the request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DISP_FAST;
        end else begin
            state_q <= req;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q <= 1'b0;
        end else begin
            unique case (state_q)
                DISP_FAST:   led_q <= ~phase;
                DISP_FRAME5,
                DISP_FRAME4,
                DISP_FRAME3: led_q <= ({1'b0, slot} < lit_slots(state_q));
                DISP_USER:   led_q <= user_led;
                default:     led_q <= 1'b0;
            endcase
        end
    end

    assign led = led_q;

endmodule

// File: rtl/led_status_blinker_chk.sv
module led_status_blinker_chk
    import led_blink_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pwr_state,
    input logic              user_led,
    input logic              led,
    input disp_e             state_q,
    input logic              restart,
    input logic              phase,
    input logic              slot_tick,
    input logic [SLOT_W-1:0] slot
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_fast_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DISP_FAST |=> led == !$past(phase));

    p_frame5_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DISP_FRAME5 |=> led == ($past(slot) < 3'd5));

    p_frame4_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DISP_FRAME4 |=> led == ($past(slot) < 3'd4));

    p_frame3_lit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DISP_FRAME3 |=> led == ($past(slot) < 3'd3));

    p_user_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == DISP_USER |=> led == $past(user_led));

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (slot == '0 && !phase));

    p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !slot_tick) |=> $stable(slot));

    p_cfg_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pwr_state != 2'd3 && pwr_state == $past(pwr_state)) |-> !restart);

endmodule

bind led_status_blinker led_status_blinker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_state (pwr_state),
    .user_led  (user_led),
    .led       (led),
    .state_q   (state_q),
    .restart   (restart),
    .phase     (phase),
    .slot_tick (slot_tick),
    .slot      (slot)
);

// File: tb/led_status_blinker_tb.sv
module led_status_blinker_tb;

    localparam int CLK_HZ  = 48;
    localparam int BASE_HZ = 12;
    localparam int H       = CLK_HZ / BASE_HZ;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr = 2'd0;
    logic       done = 1'b0;
    logic       uled = 1'b0;
    logic       led;

    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    int   m_cur = 0;
    int   m_age = 0;
    logic [7:0] lfsr = 8'hA5;

    always #2 clk = ~clk;

    led_status_blinker #(.CLK_HZ(CLK_HZ), .BASE_HZ(BASE_HZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_state (pwr),
        .cfg_done  (done),
        .user_led  (uled),
        .led       (led)
    );

    // Model codes: 0 fast, 1 five lit, 2 four lit, 3 three lit, 4 user.
    function automatic int req_of(input logic [1:0] p, input logic d);
        if (p == 2'd3) return d ? 4 : 3;
        return int'(p);
    endfunction

    function automatic logic pat(input int cur, input int age, input logic u);
        int lit;
        if (cur == 0) return ((age / H) % 2) == 0;
        if (cur == 4) return u;
        lit = (cur == 1) ? 5 : (cur == 2) ? 4 : 3;
        return ((age / (2 * H)) % 8) < lit;
    endfunction

    function automatic string tag_of(input int cur);
        case (cur)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s led=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a negedge; advances one clock and checks at the next negedge.
    task automatic step(input string tag);
        logic  exp;
        string t;
        int    r;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        uled = lfsr[0];
        @(posedge clk);
        exp = pat(m_cur, m_age, uled);
        t = (tag != "") ? tag : ((m_age == 0) ? "R7" : tag_of(m_cur));
        r = req_of(pwr, done);
        if (r != m_cur) begin
            m_cur = r;
            m_age = 0;
        end else begin
            m_age++;
        end
        @(negedge clk);
        check(t, led, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R1", led, 1'b0);
        end
        pwr = 2'd0;
        done = 1'b0;
        rst_n = 1'b1;
        m_cur = 0;
        m_age = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R2: idle fast blink
        repeat (10 * H) step("");
        // R3, R4, R5: each frame state over three frames
        for (int c = 1; c <= 3; c++) begin
            pwr = 2'(c);
            done = 1'b0;
            repeat (3 * 16 * H + 3) step("");
        end
        // R8: cfg_done toggling in non-ready states
        for (int c = 0; c <= 2; c++) begin
            pwr = 2'(c);
            step("R7");
            for (int k = 0; k < 2 * 16 * H; k++) begin
                if (k % 7 == 3) done = ~done;
                step("R8");
            end
        end
        // R6: user pass-through
        pwr = 2'd3;
        done = 1'b1;
        repeat (25 * H) step("");
        // R7: sweep every pair of input settings with varied hold times
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                pwr = 2'(a >> 1);
                done = a[0];
                repeat (5 + ((a * 8 + b) % 33)) step("");
                pwr = 2'(b >> 1);
                done = b[0];
                repeat (2 * H + 3) step("");
            end
        end
        // R1: reset in the middle of a frame, then restart from fast blink
        pwr = 2'd1;
        repeat (11) step("");
        do_reset();
        repeat (4 * H) step("R1");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule